// File: doc/BRIEF.md
# Three-Wire Serial Memory Shifter

This block moves between zero and eight bits per command over a three-wire serial link to an external memory. The link has one clock, one shared data line and a chip select. The chip select is driven elsewhere, and the block never touches it. The data line is bidirectional. The block splits it into a driven value (`sdo`), an output enable (`sdo_oe`) and a sampled input (`sdi`), and the pad combines them outside. The serial clock runs at `SCLK_HZ`, which is 500 kHz by default, and is derived from the system clock.

Software writes the 8-bit data register while the block is idle, then writes a control byte to start a transfer. The control byte has these fields:

| Bits | Field | Meaning |
|------|-------|---------|
| 3:0 | count | number of clock pulses |
| 4 | read | 1 for a read, 0 for a write |
| 5 | release | 1 to let the data line float once the last bit is sampled |
| 6 | — | ignored |
| 7 | ready-wait | 1 to wait for the memory to signal ready |

While a transfer runs, `busy` is high. `done_irq` pulses when `busy` drops.

A finished write can be held open until the memory reports ready. The memory does this by pulling the floated data line high, and the block only waits when both release and ready-wait are set.

The controller has four states:

| State | What it does |
|-------|--------------|
| IDLE | waits for a command |
| CLK_LOW | serial clock low; data launched |
| CLK_HIGH | serial clock high; data sampled at entry |
| WAIT_READY | clock parked low; watching for a ready edge |

The transitions are:

| From | To | Condition |
|------|----|-----------|
| IDLE | CLK_LOW | a command with a nonzero count (*start*) |
| CLK_LOW | CLK_HIGH | half period elapsed (*rise*) |
| CLK_HIGH | CLK_LOW | half period elapsed, bits remain (*fall*) |
| CLK_HIGH | IDLE | half period elapsed, last bit, no ready-wait (*finish*) |
| CLK_HIGH | WAIT_READY | half period elapsed, last bit, ready-wait and release both set (*park*) |
| WAIT_READY | IDLE | `sdi` goes from 0 to 1 (*ready*) |

Top module: `ser3w_engine`

## Requirements
- R1: After reset, `sclk`, `sdo`, `sdo_oe`, `busy` and `done_irq` are 0, and `data_out` is 0.
- R2: A command whose count field (bits 3:0) is N, with N from 1 to 8, gives exactly N rising edges on `sclk`. Each high phase and each low phase lasts `SYS_CLK_HZ/(2*SCLK_HZ)` system clocks. A count above 8 acts as 8. `sclk` is low whenever `busy` is low.
- R3: In a write (bit 4 = 0), the data bits leave on `sdo` most significant first, starting from bit 7 of the data register. `sdo` changes only while `sclk` is low, and it holds steady through every high phase.
- R4: At each rising edge of `sclk`, the data register shifts left by one and takes in `sdi` as its new bit 0, in reads and writes alike. After N bits the register therefore holds the old value shifted left by N, with the N sampled bits right-justified and most significant first.
- R5: In a read (bit 4 = 1), `sdo_oe` stays 0 for the whole command. In a write, `sdo_oe` is 1 from the start of the command until the last rising edge.
- R6: With release set (bit 5 = 1), `sdo_oe` drops to 0 at the last rising edge of `sclk`. With release clear, a write leaves `sdo_oe` at 1 after completion, and a read leaves it at 0.
- R7: With ready-wait (bit 7) and release both set, `busy` stays high after the last clock pulse until `sdi` is seen going from 0 to 1. With release clear, ready-wait has no effect.
- R8: A command with count 0 produces no clock pulse and raises neither `busy` nor `done_irq`. It sets `sdo_oe` to the inverse of bit 5.
- R9: `done_irq` is high for exactly one cycle: the first cycle in which `busy` reads 0 after a transfer.
- R10: While `busy` is high, writes to the control byte and to the data register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cmd_we | input | 1 | control byte write strobe |
| cmd_cfg | input | 8 | control byte: ready-wait, ignored, release, read, count[3:0] |
| data_we | input | 1 | data register write strobe |
| data_in | input | 8 | value written into the data register |
| data_out | output | 8 | data register contents |
| busy | output | 1 | transfer in progress |
| done_irq | output | 1 | one-cycle completion pulse |
| sclk | output | 1 | serial clock, idles low |
| sdo | output | 1 | driven value of the data line |
| sdo_oe | output | 1 | output enable of the data line |
| sdi | input | 1 | sampled value of the data line |

## Verification
Several properties are checked on every cycle: the clock stays low while idle, `sdo` holds steady through high phases, and a read never enables the driver. The completion pulse must coincide with the fall of `busy` and last a single cycle. The data register must stay frozen while busy except at clock rises, and a zero-count command must leave the block idle with the enable set from the release bit. Other behaviour can only be shown by the bench scenarios:
- the exact pulse count and phase widths;
- the MSB-first order of shifted-out bits;
- the final register contents after a mix of shift and sample;
- the release of the line at the last edge;
- holding for a ready edge, and ignoring ready-wait when release is clear.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CLK_LOW  = 2'd1,
        ST_CLK_HIGH = 2'd2,
        ST_WAIT_RDY = 2'd3
    } ser3w_state_e;

    // control byte layout
    typedef struct packed {
        logic       wait_rdy;   // bit 7
        logic       unused;     // bit 6
        logic       release_end;// bit 5
        logic       rd;         // bit 4
        logic [3:0] cnt;        // bits 3:0
    } ser3w_cfg_t;

endpackage

// File: rtl/ser3w_halftick.sv
module ser3w_halftick #(
    parameter int HALF_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TMR_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [TMR_W-1:0] LAST = TMR_W'(HALF_CYC - 1);

    logic [TMR_W-1:0] tmr_q;

    assign tick = run && (tmr_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (!run || tick) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end
endmodule

// File: rtl/ser3w_shreg.sv
module ser3w_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[DATA_W-2:0], bit_in};
        end else if (load_en) begin
            q <= load_val;
        end
    end
endmodule

// File: rtl/ser3w_rise.sv
module ser3w_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic din_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din;
    end

    assign rise = din && !din_q;
endmodule

// File: rtl/ser3w_engine.sv
module ser3w_engine
    import ser3w_pkg::*;
#(
    parameter int SYS_CLK_HZ = 125_000_000,
    parameter int SCLK_HZ    = 500_000,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_cfg,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              busy,
    output logic              done_irq,
    output logic              sclk,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              sdi
);
    localparam int HALF_CYC = (SYS_CLK_HZ / (2 * SCLK_HZ) > 0) ?
                              SYS_CLK_HZ / (2 * SCLK_HZ) : 1;
    localparam int LEFT_W   = $clog2(DATA_W + 1);

    ser3w_state_e        state_q, state_d;
    ser3w_cfg_t          new_cfg;
    ser3w_cfg_t          cfg_q;
    logic [LEFT_W-1:0]   left_q;
    logic [LEFT_W-1:0]   cnt_eff;
    logic                sclk_q, sdo_q, oe_q, irq_q;
    logic                tick, rdy_rise, last_bit, park;
    logic                shift_en, load_en, timer_run;
    logic [DATA_W-1:0]   sh_q;

    assign new_cfg  = ser3w_cfg_t'(cmd_cfg);
    assign cnt_eff  = (int'(new_cfg.cnt) > DATA_W) ? LEFT_W'(DATA_W)
                                                   : LEFT_W'(new_cfg.cnt);
    assign last_bit = (left_q == LEFT_W'(1));
    assign park     = cfg_q.wait_rdy && cfg_q.release_end;

    assign timer_run = (state_q == ST_CLK_LOW) || (state_q == ST_CLK_HIGH);
    assign shift_en  = (state_q == ST_CLK_LOW) && tick;
    assign load_en   = (state_q == ST_IDLE) && data_we;

    ser3w_halftick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .tick  (tick)
    );

    ser3w_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_val (data_in),
        .shift_en (shift_en),
        .bit_in   (sdi),
        .q        (sh_q)
    );

    ser3w_rise u_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sdi),
        .rise  (rdy_rise)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_we && (cnt_eff != '0)) state_d = ST_CLK_LOW;
            end
            ST_CLK_LOW: begin
                if (tick) state_d = ST_CLK_HIGH;
            end
            ST_CLK_HIGH: begin
                if (tick) begin
                    if (!last_bit)  state_d = ST_CLK_LOW;
                    else if (park)  state_d = ST_WAIT_RDY;
                    else            state_d = ST_IDLE;
                end
            end
            ST_WAIT_RDY: begin
                if (rdy_rise) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and per-command registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            left_q <= '0;
            sclk_q <= 1'b0;
            sdo_q  <= 1'b0;
            oe_q   <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_we) begin
                        cfg_q <= new_cfg;
                        if (cnt_eff == '0) begin
                            oe_q <= !new_cfg.release_end;
                        end else begin
                            left_q <= cnt_eff;
                            sdo_q  <= sh_q[DATA_W-1];
                            oe_q   <= !new_cfg.rd;
                        end
                    end
                end
                ST_CLK_LOW: begin
                    if (tick) begin
                        sclk_q <= 1'b1;
                        if (last_bit && cfg_q.release_end) oe_q <= 1'b0;
                    end
                end
                ST_CLK_HIGH: begin
                    if (tick) begin
                        sclk_q <= 1'b0;
                        left_q <= left_q - 1'b1;
                        if (last_bit) begin
                            if (!park) irq_q <= 1'b1;
                        end else begin
                            sdo_q <= sh_q[DATA_W-1];
                        end
                    end
                end
                ST_WAIT_RDY: begin
                    if (rdy_rise) irq_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done_irq = irq_q;
    assign sclk     = sclk_q;
    assign sdo      = sdo_q;
    assign sdo_oe   = oe_q;
    assign data_out = sh_q;

endmodule

// File: rtl/ser3w_engine_chk.sv
module ser3w_engine_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_we,
    input logic [7:0]        cmd_cfg,
    input logic [DATA_W-1:0] data_out,
    input logic              busy,
    input logic              done_irq,
    input logic              sclk,
    input logic              sdo,
    input logic              sdo_oe
);
    logic rd_lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rd_lat <= 1'b0;
        else if (cmd_we && !busy)  rd_lat <= cmd_cfg[4];
    end

    p_sclk_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    p_sdo_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo));

    p_read_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_lat) |-> !sdo_oe);

    p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy && cmd_cfg[3:0] == 4'd0)
        |=> (!busy && !done_irq && sdo_oe == !$past(cmd_cfg[5])));

    p_irq_at_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_irq);

    p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !busy);

    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    p_data_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$rose(sclk)) |-> $stable(data_out));

endmodule

bind ser3w_engine ser3w_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_we   (cmd_we),
    .cmd_cfg  (cmd_cfg),
    .data_out (data_out),
    .busy     (busy),
    .done_irq (done_irq),
    .sclk     (sclk),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
);

// File: tb/ser3w_engine_test.sv
module ser3w_engine_test;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_cfg = 8'h00;
    logic       data_we = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;
    logic       busy, done_irq, sclk, sdo, sdo_oe;
    logic       sdi = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ser3w_engine #(.SYS_CLK_HZ(8_000_000), .SCLK_HZ(500_000), .DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_cfg(cmd_cfg),
        .data_we(data_we), .data_in(data_in), .data_out(data_out),
        .busy(busy), .done_irq(done_irq), .sclk(sclk), .sdo(sdo),
        .sdo_oe(sdo_oe), .sdi(sdi)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int eff_cnt(input logic [3:0] c);
        return (c > 4'd8) ? 8 : int'(c);
    endfunction

    function automatic logic [7:0] exp_data(input logic [7:0] pre,
                                            input logic [7:0] samp, input int n);
        logic [15:0] w;
        logic [7:0]  m;
        m = 8'((16'd1 << n) - 16'd1);
        w = (16'(pre) << n) | 16'(samp & m);
        return w[7:0];
    endfunction

    function automatic logic [7:0] exp_sent(input logic [7:0] pre, input int n);
        return pre >> (8 - n);
    endfunction

    task automatic run_cmd(input logic [7:0] cfg, input logic [7:0] pre,
                           input logic [7:0] samp, input bit poke);
        int n = eff_cnt(cfg[3:0]);
        bit rd = cfg[4];
        bit fl = cfg[5];
        bit waitm = cfg[7] && cfg[5];
        int rises = 0, hi_cyc = 0, guard = 0, early_irq = 0;
        bit prev = 0, oe_bad = 0, done = 0, waited = 0;
        logic [7:0] sent = 8'h00;
        logic [7:0] m = 8'((16'd1 << n) - 16'd1);
        @(negedge clk);
        data_we = 1'b1; data_in = pre;
        @(negedge clk);
        data_we = 1'b0;
        sdi = samp[n-1];
        cmd_cfg = cfg; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        while (!done && guard < 4000) begin
            guard++;
            if (!busy) begin
                done = 1;
                check(done_irq == 1'b1, "R9", "irq at busy fall", int'(done_irq), 1);
            end else begin
                if (done_irq) early_irq++;
                cmd_we = 1'b0; data_we = 1'b0;
                if (sclk) hi_cyc++;
                if (sclk && !prev) begin
                    rises++;
                    sent = {sent[6:0], sdo};
                    if (fl && rises == n)
                        check(sdo_oe == 1'b0, "R6", "release at last rise", int'(sdo_oe), 0);
                    sdi = (rises < n) ? samp[n-1-rises] : 1'b0;
                    if (poke && rises == 2) begin
                        cmd_we = 1'b1; cmd_cfg = 8'h08;
                        data_we = 1'b1; data_in = ~pre;
                    end
                end
                if (rd && sdo_oe) oe_bad = 1;
                if (!rd && !(fl && rises >= n) && !sdo_oe) oe_bad = 1;
                if (waitm && rises == n && !sclk && !waited) begin
                    waited = 1;
                    repeat (12) @(negedge clk);
                    check(busy == 1'b1, "R7", "busy held for ready", int'(busy), 1);
                    sdi = 1'b1;
                end
                prev = sclk;
                @(negedge clk);
            end
        end
        cmd_we = 1'b0; data_we = 1'b0;
        check(done == 1, "R7", "command completed", int'(done), 1);
        check(rises == n, "R2", "rising edge count", rises, n);
        check(hi_cyc == n * HALF, "R2", "high phase cycles", hi_cyc, n * HALF);
        if (!rd)
            check((sent & m) == exp_sent(pre, n), "R3", "bits sent", int'(sent & m),
                  int'(exp_sent(pre, n)));
        check(data_out == exp_data(pre, samp, n), poke ? "R10" : "R4", "data register",
              int'(data_out), int'(exp_data(pre, samp, n)));
        check(oe_bad == 0, "R5", "enable during command", int'(oe_bad), 0);
        check(early_irq == 0, "R9", "irq while busy", early_irq, 0);
        check(sdo_oe == (!rd && !fl), "R6", "enable after command", int'(sdo_oe),
              int'(!rd && !fl));
        @(negedge clk);
        check(done_irq == 1'b0, "R9", "irq single cycle", int'(done_irq), 0);
        sdi = 1'b0;
    endtask

    task automatic zero_cmd(input logic [7:0] cfg);
        int bad = 0;
        @(negedge clk);
        cmd_cfg = cfg; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        repeat (3 * HALF) begin
            if (busy || sclk || done_irq) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R8", "no activity on zero count", bad, 0);
        check(sdo_oe == !cfg[5], "R8", "enable follows release bit", int'(sdo_oe),
              int'(!cfg[5]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        check(sclk == 0 && sdo == 0 && sdo_oe == 0, "R1", "line outputs in reset",
              int'({sclk, sdo, sdo_oe}), 0);
        check(busy == 0 && done_irq == 0 && data_out == 0, "R1", "status in reset",
              int'({busy, done_irq, data_out}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_cmd(8'h08, 8'hA5, 8'h00, 0);   // R3 write 8, driven after
        run_cmd(8'h18, 8'h3C, 8'hC9, 0);   // R4 read 8
        run_cmd(8'h33, 8'hF0, 8'h05, 0);   // R6 read 3, released
        run_cmd(8'hA5, 8'h96, 8'h00, 0);   // R7 write 5, wait for ready
        run_cmd(8'h85, 8'h5A, 8'h00, 0);   // R7 wait ignored without release
        run_cmd(8'h0C, 8'h81, 8'h42, 0);   // R2 count above 8 acts as 8
        run_cmd(8'h01, 8'h80, 8'h01, 0);   // R2 single bit
        run_cmd(8'h48, 8'h77, 8'h12, 1);   // R10 writes while busy ignored
        zero_cmd(8'h00);                   // R8 release clear
        zero_cmd(8'h30);                   // R8 release set
        zero_cmd(8'hA0);                   // R8 wait set too

        for (int i = 0; i < 40; i++) begin
            logic [7:0] c;
            c = 8'($urandom);
            c[3:0] = 4'($urandom_range(1, 8));
            run_cmd(c, 8'($urandom), 8'($urandom), 0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule